// File: doc/BRIEF.md
# ADC Result Buffer Controller

This block sits between an analog-to-digital converter sequencer and a processor bus. Each time the sequencer presents a valid 10-bit result, the block stores it in a 16-entry result memory. The write position advances on every stored result. After a programmed number of acquire/convert sequences, the block sets an interrupt flag and a done flag. One sequence holds one, two or four channel conversions. The bus reads the memory through a read-only port that returns each entry as a 16-bit word.

Split mode lets software unload one part of the memory while the other part is filling. In this mode the memory acts as two 8-entry halves, and the fill moves to the other half at every interrupt event. A status output shows which half is being filled. The block flags any configuration that would need more entries than the active region holds. In that case it keeps every write inside the region.

Top module: `adc_result_buffer`

## Requirements
- R1: After reset, `irq_flag`, `done_flag` and `fill_half` are 0, every memory entry reads 0, and the first stored result goes to entry 0.
- R2: The k-th result stored since the last interrupt event (k from 0) goes to entry base+k, where base is 0 or 8. A read returns the stored value in bits 9:0, with bits 15:10 at zero.
- R3: A bus write (`bus_wr`=1) never changes the contents of the memory, whatever its address and data.
- R4: `irq_flag` and `done_flag` are both set at the clock edge that stores the last conversion of sequence number `seq_cfg`+1 (so 1 to 16 sequences per interrupt). Neither flag is set before that edge.
- R5: `chan_sel` sets the conversions per sequence: 2'b00 gives 1, 2'b01 gives 2, and 2'b10 or 2'b11 gives 4.
- R6: `irq_flag` stays set until a cycle with `irq_clr`=1 clears it. If an interrupt event and `irq_clr` fall in the same cycle, the flag is set.
- R7: `done_flag` clears at the edge that stores the next result that is not itself an interrupt event.
- R8: With `split_en`=0, the first result after an interrupt event goes to entry 0 and `fill_half` stays 0.
- R9: With `split_en`=1, filling starts in the half at entries 0..7 (`fill_half`=0). Each interrupt event toggles `fill_half`, and the next result goes to entry 8 when `fill_half` is 1 and to entry 0 when it is 0.
- R10: `cfg_err` is 1 exactly when the conversions per sequence times (`seq_cfg`+1) exceed 16 with `split_en`=0, or exceed 8 with `split_en`=1.
- R11: When a fill would pass the end of the active region (entries 0..15 unsplit, base..base+7 split), every extra result overwrites the region's last entry. The interrupt still follows the sequence count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Conversion result strobe |
| res_data | input | 10 | Conversion result |
| chan_sel | input | 2 | Conversions per sequence code |
| seq_cfg | input | 4 | Sequences per interrupt minus one |
| split_en | input | 1 | Two-half alternating fill mode |
| irq_clr | input | 1 | Clears the interrupt flag |
| bus_addr | input | 4 | Bus entry address for read (and ignored write) |
| bus_wr | input | 1 | Bus write attempt, ignored |
| bus_wdata | input | 16 | Bus write data, ignored |
| bus_rdata | output | 16 | Zero-extended entry at `bus_addr` |
| irq_flag | output | 1 | Sticky interrupt flag |
| done_flag | output | 1 | Fill-complete flag |
| fill_half | output | 1 | Half currently being filled |
| cfg_err | output | 1 | Illegal conversions-per-interrupt configuration |

## Verification
The clamp at the end of a split half is the hardest case to reach from the ports. To get there, split mode must first have toggled back to the lower half. Then a legal-count interrupt must leave the counters at zero, and only then may a configuration that overflows 8 entries be applied. The stimulus runs two full split fills first, switches to two channels with five sequences, and sends ten results. The scoreboard keeps a shadow copy of the memory. It expects the last three results to land on entry 7, so only the final one survives, and it expects the interrupt to arrive on the tenth result.

// File: rtl/adcbuf_pkg.sv
package adcbuf_pkg;

   // shift amount for conversions per sequence: 00->1, 01->2, 1x->4
   function automatic logic [1:0] chan_shift(input logic [1:0] code);
      logic [1:0] s;
      case (code)
         2'b00:   s = 2'd0;
         2'b01:   s = 2'd1;
         default: s = 2'd2;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/adcbuf_seq_ctrl.sv
module adcbuf_seq_ctrl #(
   parameter int DEPTH = 16,
   parameter int SEQ_W = 4,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             res_valid,
   input  logic [1:0]       chan_sel,
   input  logic [SEQ_W-1:0] seq_cfg,
   input  logic             split_en,
   output logic [AW-1:0]    wr_addr,
   output logic             evt,
   output logic             fill_half,
   output logic             cfg_err
);
   localparam int HALF  = DEPTH / 2;
   localparam int OFF_W = (SEQ_W + 3 > AW + 1) ? SEQ_W + 3 : AW + 1;

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [1:0]       chan_idx;
   logic [SEQ_W-1:0] seq_idx;
   logic [1:0]       sh;
   logic [1:0]       chan_last;
   logic             last_chan;
   logic             last_seq;
   logic [OFF_W-1:0] offset;
   logic [OFF_W-1:0] off_cl;
   logic [OFF_W-1:0] region_words;
   logic [OFF_W-1:0] conv_total;
   logic [AW-1:0]    base;

   always_comb begin
      sh        = adcbuf_pkg::chan_shift(chan_sel);
      chan_last = (sh == 2'd0) ? 2'd0 : (sh == 2'd1) ? 2'd1 : 2'd3;
      last_chan = (chan_idx >= chan_last);
      last_seq  = (seq_idx >= seq_cfg);
      evt       = res_valid && last_chan && last_seq;
      offset    = (OFF_W'(seq_idx) << sh) + OFF_W'(chan_idx);
      region_words = split_en ? OFF_W'(HALF) : OFF_W'(DEPTH);
      conv_total   = (OFF_W'(seq_cfg) + OFF_W'(1)) << sh;
      cfg_err      = (conv_total > region_words);
      off_cl    = (offset >= region_words) ? (region_words - OFF_W'(1)) : offset;
      base      = (split_en && fill_half) ? AW'(HALF) : '0;
      wr_addr   = base + off_cl[AW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chan_idx <= '0;
         seq_idx  <= '0;
      end else if (res_valid) begin
         if (last_chan) begin
            chan_idx <= '0;
            seq_idx  <= last_seq ? '0 : seq_idx + 1'b1;
         end else begin
            chan_idx <= chan_idx + 2'd1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         fill_half <= 1'b0;
      else if (!split_en) fill_half <= 1'b0;
      else if (evt)       fill_half <= ~fill_half;
   end

   // R8
   unsplit_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !split_en |=> !fill_half);

   // R9
   half_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (split_en && evt) |=> (fill_half != $past(fill_half)));

endmodule

// File: rtl/adcbuf_flags.sv
module adcbuf_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic res_valid,
   input  logic irq_clr,
   output logic irq_flag,
   output logic done_flag
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_flag  <= 1'b0;
         done_flag <= 1'b0;
      end else begin
         if (evt)          irq_flag <= 1'b1;
         else if (irq_clr) irq_flag <= 1'b0;
         if (evt)            done_flag <= 1'b1;
         else if (res_valid) done_flag <= 1'b0;
      end
   end

   // R4
   flags_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> (irq_flag && done_flag));

   // R6
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !irq_clr) |=> irq_flag);

   // R7
   done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_flag && res_valid && !evt) |=> !done_flag);

endmodule

// File: rtl/adcbuf_mem.sv
module adcbuf_mem #(
   parameter int DEPTH     = 16,
   parameter int DATA_W    = 10,
   parameter int WORD_W    = 16,
   parameter bit LEFT_JUST = 1'b0,
   localparam int AW       = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   input  logic              bus_wr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] rd_data
);
   localparam int PAD_W = WORD_W - DATA_W;

   generate
      if (PAD_W < 1) begin : g_bad_width
         $error("WORD_W must exceed DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] store [DEPTH];
   logic [DATA_W-1:0] sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) store[i] <= '0;
      end else if (we) begin
         store[wr_addr] <= wr_data;
      end
   end

   always_comb sel = store[rd_addr];

   generate
      if (LEFT_JUST) begin : g_left
         always_comb rd_data = {sel, {PAD_W{1'b0}}};
      end else begin : g_right
         always_comb rd_data = {{PAD_W{1'b0}}, sel};
      end
   endgenerate

   // R3
   bus_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !we && (bus_wdata != rd_data)) |=>
         (!$stable(rd_addr) || (rd_data == $past(rd_data))));

   // R2
   pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      LEFT_JUST || (rd_data[WORD_W-1:DATA_W] == '0));

endmodule

// File: rtl/adc_result_buffer.sv
module adc_result_buffer #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 10,
   parameter int WORD_W = 16,
   parameter int SEQ_W  = 4,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_valid,
   input  logic [DATA_W-1:0] res_data,
   input  logic [1:0]        chan_sel,
   input  logic [SEQ_W-1:0]  seq_cfg,
   input  logic              split_en,
   input  logic              irq_clr,
   input  logic [AW-1:0]     bus_addr,
   input  logic              bus_wr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   output logic              irq_flag,
   output logic              done_flag,
   output logic              fill_half,
   output logic              cfg_err
);
   logic [AW-1:0] wr_addr;
   logic          evt;

   adcbuf_seq_ctrl #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .chan_sel(chan_sel),
      .seq_cfg(seq_cfg), .split_en(split_en), .wr_addr(wr_addr), .evt(evt),
      .fill_half(fill_half), .cfg_err(cfg_err)
   );

   adcbuf_flags u_flags (
      .clk(clk), .rst_n(rst_n), .evt(evt), .res_valid(res_valid),
      .irq_clr(irq_clr), .irq_flag(irq_flag), .done_flag(done_flag)
   );

   adcbuf_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .WORD_W(WORD_W)) u_mem (
      .clk(clk), .rst_n(rst_n), .we(res_valid), .wr_addr(wr_addr),
      .wr_data(res_data), .rd_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .rd_data(bus_rdata)
   );

   // R11
   split_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && split_en) |-> (wr_addr[AW-1] == fill_half));

endmodule

// File: tb/adc_result_buffer_tb.sv
`timescale 1ns/1ps
module adc_result_buffer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        res_valid = 1'b0;
   logic [9:0]  res_data = '0;
   logic [1:0]  chan_sel = 2'b00;
   logic [3:0]  seq_cfg = 4'd0;
   logic        split_en = 1'b0;
   logic        irq_clr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq_flag, done_flag, fill_half, cfg_err;

   int checks = 0;
   int errors = 0;

   // bench model
   logic [9:0] shadow [16];
   int         exp_q [$];
   int         m_cnt = 0;
   bit         m_half = 0;
   bit         m_irq = 0;
   bit         m_done = 0;

   always #4 clk = ~clk;

   adc_result_buffer u_dut (
      .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
      .chan_sel(chan_sel), .seq_cfg(seq_cfg), .split_en(split_en),
      .irq_clr(irq_clr), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_flag(irq_flag),
      .done_flag(done_flag), .fill_half(fill_half), .cfg_err(cfg_err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int chans();
      return (chan_sel == 2'b00) ? 1 : (chan_sel == 2'b01) ? 2 : 4;
   endfunction

   // driver: sends one result and pushes its expected entry
   task automatic send(input logic [9:0] d, input bit clr);
      int region = split_en ? 8 : 16;
      int base   = (split_en && m_half) ? 8 : 0;
      int off    = (m_cnt < region) ? m_cnt : region - 1;
      bit ev     = (m_cnt + 1 == chans() * (int'(seq_cfg) + 1));
      @(negedge clk);
      res_valid = 1'b1; res_data = d; irq_clr = clr;
      shadow[base + off] = d;
      exp_q.push_back(base + off);
      @(negedge clk);
      res_valid = 1'b0; irq_clr = 1'b0;
      if (ev) begin
         m_cnt = 0; m_irq = 1; m_done = 1;
         if (split_en) m_half = ~m_half;
      end else begin
         m_cnt++; m_done = 0;
         if (clr) m_irq = 0;
      end
      check("R4/R6 irq", irq_flag, m_irq);
      check("R4/R7 done", done_flag, m_done);
      check("R9 half", fill_half, m_half);
   endtask

   // monitor: pops expected entries and compares through the read port
   task automatic drain(input string req);
      while (exp_q.size() > 0) begin
         int a = exp_q.pop_front();
         @(negedge clk);
         bus_addr = a[3:0];
         #1;
         check(req, bus_rdata, {6'b0, shadow[a]});
      end
   endtask

   task automatic clear_irq();
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
      m_irq = 0;
      check("R6 clear", irq_flag, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog timeout");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) shadow[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 irq", irq_flag, 0);
      check("R1 done", done_flag, 0);
      check("R1 half", fill_half, 0);
      for (int i = 0; i < 16; i++) exp_q.push_back(i);
      drain("R1 mem zero");

      // R2 R4 R8 unsplit, 1 channel, 4 sequences
      seq_cfg = 4'd3;
      send(10'h3FF, 0); send(10'h001, 0); send(10'h155, 0); send(10'h2AA, 0);
      drain("R2 R4 unsplit fill");
      repeat (3) @(negedge clk);
      check("R6 hold", irq_flag, 1);
      clear_irq();
      send(10'h0F0, 0);
      check("R8 restart at 0", exp_q[0], 0);
      check("R7 done low", done_flag, 0);
      send(10'h00F, 0); send(10'h111, 0); send(10'h222, 0);
      drain("R8 refill");

      // R5 two channels x 3 sequences, four channels x 2 sequences
      clear_irq();
      chan_sel = 2'b01; seq_cfg = 4'd2;
      for (int i = 0; i < 6; i++) send(10'(40 + i), 0);
      drain("R5 two-channel");
      clear_irq();
      chan_sel = 2'b11; seq_cfg = 4'd1;
      for (int i = 0; i < 8; i++) send(10'(300 + 7 * i), 0);
      drain("R5 four-channel");
      check("R10 legal 8", cfg_err, 0);

      // R3 bus writes ignored
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         bus_addr = 4'(i); bus_wr = 1'b1; bus_wdata = 16'hFFFF;
         @(negedge clk);
         bus_wr = 1'b0;
         #1;
         check("R3 write ignored", bus_rdata, {6'b0, shadow[i]});
      end

      // R9 split alternating halves, set wins over clear on last
      clear_irq();
      chan_sel = 2'b00; seq_cfg = 4'd7; split_en = 1'b1;
      @(negedge clk);
      check("R9 start half", fill_half, 0);
      for (int i = 0; i < 8; i++) send(10'(500 + i), (i == 7));
      check("R6 set wins", irq_flag, 1);
      for (int i = 0; i < 8; i++) send(10'(600 + i), 0);
      drain("R9 split halves");

      // R10 legality
      split_en = 1'b0; chan_sel = 2'b10; seq_cfg = 4'd4;
      #1 check("R10 unsplit 20", cfg_err, 1);
      chan_sel = 2'b00; seq_cfg = 4'd15;
      #1 check("R10 unsplit 16", cfg_err, 0);
      split_en = 1'b1; chan_sel = 2'b01; seq_cfg = 4'd4;
      #1 check("R10 split 10", cfg_err, 1);

      // R11 clamp inside lower half
      clear_irq();
      for (int i = 0; i < 10; i++) send(10'(700 + i), 0);
      drain("R11 clamp");
      @(negedge clk); bus_addr = 4'd7; #1;
      check("R11 last entry", bus_rdata, 16'(709));
      @(negedge clk); bus_addr = 4'd8; #1;
      check("R11 other half kept", bus_rdata, 16'(600));

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule